// File: doc/BRIEF.md
# Pipelined CORDIC Activation Unit

This block evaluates a neural-network activation function on a stream of signed fixed-point samples. Each sample arrives with its own function code: rectified linear, hyperbolic tangent or logistic sigmoid. Because the code travels down the pipeline with its sample, one instance can serve several layers or channels in turn. The code may change on every clock, and there is no drain or flush between functions.

Tangent and sigmoid share one shift-and-add datapath. First, hyperbolic rotation iterations produce a scaled cosh/sinh pair. Then linear vectoring iterations divide the sinh term by the cosh term. The common gain of the rotation cancels in that quotient. Sigmoid is computed as (1 + tanh(x/2)) / 2, so it uses the same path with a halved argument. Rectified linear skips the iterations but still passes through every stage. The pipeline is nine registers deep and accepts one sample per clock. Arguments outside the range where the rotations converge are forced to the function's asymptote.

Samples and results are 16-bit two's complement with 12 fraction bits, so the value 1.0 is 4096.

Top module: `act_cordic_pipe`

## Requirements
- R1: A result appears on `out_valid` exactly 9 clock edges after its sample is taken with `in_valid` high. Results leave in the order the samples arrived, one per clock at most. `out_valid` is low for every slot in which no sample was taken.
- R2: The function is chosen per sample by `in_func`: 2'b00 selects ReLU, 2'b01 selects tanh, 2'b10 selects sigmoid and 2'b11 is reserved. `in_func` may change on every cycle, and each result uses the code of its own sample.
- R3: ReLU returns the sample exactly when it is zero or positive, and 0 when it is negative, over the full 16-bit range.
- R4: For |x| ≤ 4579 (about 1.118), the tanh result is within 16 LSB of round(4096·tanh(x/4096)).
- R5: For |x| ≤ 9158, the sigmoid result is within 16 LSB of round(4096/(1+e^(−x/4096))).
- R6: tanh returns exactly 4096 for x ≥ 4580 and exactly −4096 for x ≤ −4580.
- R7: sigmoid returns exactly 4096 for x ≥ 9159 and exactly 0 for x ≤ −9159.
- R8: The reserved code 2'b11 returns 0 for any sample, with `out_valid` following R1.
- R9: While `rst_n` is low, `out_valid` is low. Samples that were in flight when reset was asserted never appear after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is presented this cycle |
| in_func | input | 2 | Function code for this sample |
| in_x | input | 16 | Signed sample with 12 fraction bits |
| out_valid | output | 1 | `out_y` holds a result |
| out_y | output | 16 | Signed result with 12 fraction bits |

## Verification
ReLU uses the bypass field while tanh and sigmoid use the iteration registers. A ReLU sample can therefore sit one stage behind a sigmoid sample while the final formatter selects for a third function. The main hazard is a function tag or a saturation flag leaking into the neighbouring sample. To provoke it, the bench cycles `in_func` through all four codes on consecutive clocks, inserts bubbles between samples, and places boundary arguments on both sides of the saturation limits. Each result is judged against a value the bench computes itself from the sample's own code and argument. The bench also checks that each result arrives exactly nine edges after its sample.

// File: rtl/act_pkg.sv
package act_pkg;
    parameter int DATA_W        = 16;  // sample and result width
    parameter int FRAC          = 12;  // fraction bits at the ports
    parameter int FRAC_I        = 16;  // fraction bits inside the datapath
    parameter int GUARD_I       = 6;   // integer and sign bits inside the datapath
    parameter int HYP_ST        = 4;   // pipeline stages of hyperbolic rotation
    parameter int DIV_ST        = 4;   // pipeline stages of linear division
    parameter int ITER_PER_ST   = 3;   // iterations unrolled per stage
    parameter int CONV_LIM_MILLI = 1118; // convergence limit of rotation, x1000

    localparam int IW       = FRAC_I + GUARD_I;
    localparam int SH       = FRAC_I - FRAC;
    localparam int N_STAGES = 1 + HYP_ST + DIV_ST;

    typedef logic signed [IW-1:0] cdata_t;

    localparam cdata_t ONE_I = cdata_t'(1) <<< FRAC_I;
    localparam cdata_t LIM_I = cdata_t'((longint'(CONV_LIM_MILLI) << FRAC_I) / 1000);

    typedef enum logic [1:0] {
        FN_RELU = 2'b00,
        FN_TANH = 2'b01,
        FN_SIG  = 2'b10,
        FN_RSV  = 2'b11
    } act_fn_e;

    typedef struct packed {
        logic                     vld;
        act_fn_e                  fn;
        logic                     sat;
        logic                     neg;
        logic signed [DATA_W-1:0] byp;
        cdata_t                   cx;
        cdata_t                   cy;
        cdata_t                   cz;
    } stage_t;

    // Shift amount of the n-th hyperbolic iteration; indices 4 and 13 repeat.
    function automatic int hyp_shift(int n);
        if (n < 4)       return n + 1;
        else if (n < 14) return n;
        else             return n - 1;
    endfunction

    // atanh(2^-idx) in FRAC_I fraction bits, from the odd power series.
    function automatic cdata_t atanh_pow2(int idx);
        longint acc = 0;
        for (int k = 0; k < 24; k++) begin
            int p = idx * (2 * k + 1);
            if (p <= 48) acc += (longint'(1) <<< (48 - p)) / longint'(2 * k + 1);
        end
        return cdata_t'((acc + (longint'(1) <<< (47 - FRAC_I))) >>> (48 - FRAC_I));
    endfunction
endpackage

// File: rtl/act_prep.sv
module act_prep
    import act_pkg::*;
(
    input  logic                     in_valid,
    input  logic [1:0]               in_func,
    input  logic signed [DATA_W-1:0] in_x,
    output stage_t                   st_o
);
    always_comb begin
        cdata_t arg;
        arg = cdata_t'(in_x) <<< SH;
        if (act_fn_e'(in_func) == FN_SIG) arg = arg >>> 1;
        st_o.vld = in_valid;
        st_o.fn  = act_fn_e'(in_func);
        st_o.sat = (arg > LIM_I) || (arg < -LIM_I);
        st_o.neg = arg[IW-1];
        st_o.byp = in_x[DATA_W-1] ? '0 : in_x;
        st_o.cx  = ONE_I;
        st_o.cy  = '0;
        st_o.cz  = st_o.sat ? '0 : arg;
    end
endmodule

// File: rtl/cordic_hyp_stage.sv
module cordic_hyp_stage
    import act_pkg::*;
#(
    parameter int BASE = 0
) (
    input  stage_t st_i,
    output stage_t st_o
);
    always_comb begin
        cdata_t xv, yv, zv, xs, ys;
        xv = st_i.cx;
        yv = st_i.cy;
        zv = st_i.cz;
        for (int k = 0; k < ITER_PER_ST; k++) begin
            xs = xv >>> hyp_shift(BASE + k);
            ys = yv >>> hyp_shift(BASE + k);
            if (!zv[IW-1]) begin
                xv = xv + ys;
                yv = yv + xs;
                zv = zv - atanh_pow2(hyp_shift(BASE + k));
            end else begin
                xv = xv - ys;
                yv = yv - xs;
                zv = zv + atanh_pow2(hyp_shift(BASE + k));
            end
        end
        st_o    = st_i;
        st_o.cx = xv;
        st_o.cy = yv;
        st_o.cz = zv;
    end
endmodule

// File: rtl/cordic_div_stage.sv
module cordic_div_stage
    import act_pkg::*;
#(
    parameter int BASE  = 0,
    parameter bit FIRST = 1'b0
) (
    input  stage_t st_i,
    output stage_t st_o
);
    always_comb begin
        cdata_t yv, zv, xs;
        yv = st_i.cy;
        zv = FIRST ? '0 : st_i.cz;
        for (int k = 0; k < ITER_PER_ST; k++) begin
            xs = st_i.cx >>> (BASE + k);
            if (!yv[IW-1]) begin
                yv = yv - xs;
                zv = zv + (ONE_I >>> (BASE + k));
            end else begin
                yv = yv + xs;
                zv = zv - (ONE_I >>> (BASE + k));
            end
        end
        st_o    = st_i;
        st_o.cy = yv;
        st_o.cz = zv;
    end
endmodule

// File: rtl/act_format.sv
module act_format
    import act_pkg::*;
(
    input  stage_t                   st_i,
    output logic signed [DATA_W-1:0] y_o
);
    localparam cdata_t HALF  = (SH > 0) ? (cdata_t'(1) <<< (SH - 1)) : '0;
    localparam cdata_t ONE_O = cdata_t'(1) <<< FRAC;

    always_comb begin
        cdata_t v, rnd;
        v = (st_i.fn == FN_SIG) ? ((st_i.cz + ONE_I) >>> 1) : st_i.cz;
        rnd = (v + HALF) >>> SH;
        unique case (st_i.fn)
            FN_RELU: y_o = st_i.byp;
            FN_TANH: y_o = st_i.sat ? (st_i.neg ? -ONE_O[DATA_W-1:0] : ONE_O[DATA_W-1:0])
                                    : rnd[DATA_W-1:0];
            FN_SIG:  y_o = st_i.sat ? (st_i.neg ? '0 : ONE_O[DATA_W-1:0])
                                    : rnd[DATA_W-1:0];
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/act_cordic_pipe.sv
module act_cordic_pipe
    import act_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               in_func,
    input  logic signed [DATA_W-1:0] in_x,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_y
);
    stage_t stg_c  [N_STAGES];
    stage_t pipe_d [N_STAGES];
    stage_t pipe_q [N_STAGES];

    act_prep i_prep (
        .in_valid (in_valid),
        .in_func  (in_func),
        .in_x     (in_x),
        .st_o     (stg_c[0])
    );

    for (genvar s = 0; s < HYP_ST; s++) begin : g_hyp
        cordic_hyp_stage #(.BASE(s * ITER_PER_ST)) i_hyp (
            .st_i (pipe_q[s]),
            .st_o (stg_c[s + 1])
        );
    end

    for (genvar s = 0; s < DIV_ST; s++) begin : g_div
        cordic_div_stage #(.BASE(s * ITER_PER_ST), .FIRST(s == 0)) i_div (
            .st_i (pipe_q[HYP_ST + s]),
            .st_o (stg_c[HYP_ST + s + 1])
        );
    end

    always_comb begin
        for (int s = 0; s < N_STAGES; s++) pipe_d[s] = stg_c[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < N_STAGES; s++) pipe_q[s] <= '0;
        end else begin
            for (int s = 0; s < N_STAGES; s++) pipe_q[s] <= pipe_d[s];
        end
    end

    act_format i_fmt (
        .st_i (pipe_q[N_STAGES-1]),
        .y_o  (out_y)
    );

    assign out_valid = pipe_q[N_STAGES-1].vld;
endmodule

// File: rtl/act_cordic_checker.sv
module act_cordic_checker
    import act_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [1:0]               in_func,
    input logic signed [DATA_W-1:0] in_x,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_y
);
    localparam int LAT      = N_STAGES;
    localparam int ONE_O    = 1 << FRAC;
    localparam int TANH_LIM = int'(LIM_I >>> SH);
    localparam int SIG_LIM  = int'(LIM_I >>> (SH - 1));

    logic [3:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cyc_q <= '0;
        else if (cyc_q != 4'(LAT)) cyc_q <= cyc_q + 4'd1;
    end

    wire warm = (cyc_q == 4'(LAT));

    AST_IDLE_IN_RESET: assert property (@(posedge clk) !rst_n |-> !out_valid); // R9
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> out_valid == $past(in_valid, LAT)); // R1
    AST_RELU_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_func, LAT) == 2'b00)
        |-> int'(out_y) == (int'($past(in_x, LAT)) < 0 ? 0 : int'($past(in_x, LAT)))); // R3
    AST_TANH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_func, LAT) == 2'b01)
        |-> (int'(out_y) <= ONE_O && int'(out_y) >= -ONE_O)); // R4
    AST_SIG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_func, LAT) == 2'b10)
        |-> (int'(out_y) <= ONE_O && int'(out_y) >= 0)); // R5
    AST_TANH_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_func, LAT) == 2'b01 && int'($past(in_x, LAT)) > TANH_LIM)
        |-> int'(out_y) == ONE_O); // R6
    AST_SIG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_func, LAT) == 2'b10 && int'($past(in_x, LAT)) < -SIG_LIM)
        |-> out_y == '0); // R7
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(in_func, LAT) == 2'b11) |-> out_y == '0); // R8
endmodule

bind act_cordic_pipe act_cordic_checker i_chk (.*);

// File: tb/test_act_cordic_pipe.sv
module test_act_cordic_pipe;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [1:0]         in_func = 2'b00;
    logic signed [15:0] in_x = '0;
    logic               out_valid;
    logic signed [15:0] out_y;

    act_cordic_pipe i_act_cordic_pipe (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_func (in_func),
        .in_x (in_x), .out_valid (out_valid), .out_y (out_y)
    );

    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int cap_n = 0;
    int cap_y [64];
    int cap_c [64];
    always @(negedge clk) begin
        if (out_valid && cap_n < 64) begin
            cap_y[cap_n] = int'(out_y);
            cap_c[cap_n] = cyc;
            cap_n++;
        end
    end

    logic       drv_v [64];
    logic [1:0] drv_f [64];
    int         drv_x [64];
    int         iss_c [64];

    task automatic check(string req, int act, int exp, int tol);
        int diff = act - exp;
        tests++;
        if (diff > tol || -diff > tol) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (tol %0d)", req, act, exp, tol);
        end
    endtask

    function automatic int rnd(real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    // Expected value from the requirements; tol receives the allowed error.
    function automatic int ref_val(logic [1:0] f, int x, output int tol, output string req);
        tol = 0;
        case (f)
            2'b00: begin req = "R3"; return (x < 0) ? 0 : x; end
            2'b01: begin
                if (x > 4579)  begin req = "R6"; return 4096;  end
                if (x < -4579) begin req = "R6"; return -4096; end
                req = "R4"; tol = 16;
                return rnd(4096.0 * $tanh(real'(x) / 4096.0));
            end
            2'b10: begin
                if (x > 9158)  begin req = "R7"; return 4096; end
                if (x < -9158) begin req = "R7"; return 0;    end
                req = "R5"; tol = 16;
                return rnd(4096.0 / (1.0 + $exp(-real'(x) / 4096.0)));
            end
            default: begin req = "R8"; return 0; end
        endcase
    endfunction

    task automatic run_batch(string tag, int n);
        int k = 0;
        int nv = 0;
        @(posedge clk);
        cap_n = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = drv_v[i];
            in_func  = drv_f[i];
            in_x     = 16'(drv_x[i]);
            iss_c[i] = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (12) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (drv_v[i]) begin
                int tol;
                string req;
                int e = ref_val(drv_f[i], drv_x[i], tol, req);
                nv++;
                if (k < cap_n) begin
                    check({tag, " ", req}, cap_y[k], e, tol);
                    check({tag, " R1 latency"}, cap_c[k] - iss_c[i], 9, 0);
                end
                k++;
            end
        end
        check({tag, " R1 result count"}, cap_n, nv, 0);
    endtask

    task automatic t_reset_idle();
        @(negedge clk);
        check("R9 out_valid after reset", int'(out_valid), 0, 0);
    endtask

    task automatic t_relu();
        int xs [6] = '{-8, -1, 0, 1, 32767, -32768};
        for (int i = 0; i < 6; i++) begin drv_v[i] = 1; drv_f[i] = 2'b00; drv_x[i] = xs[i]; end
        run_batch("relu R3", 6);
    endtask

    task automatic t_tanh_sweep();
        for (int i = 0; i < 19; i++) begin drv_v[i] = 1; drv_f[i] = 2'b01; drv_x[i] = -4579 + i * 508; end
        drv_v[19] = 1; drv_f[19] = 2'b01; drv_x[19] = 4579;
        run_batch("tanh sweep R4", 20);
    endtask

    task automatic t_sig_sweep();
        for (int i = 0; i < 19; i++) begin drv_v[i] = 1; drv_f[i] = 2'b10; drv_x[i] = -9158 + i * 1017; end
        drv_v[19] = 1; drv_f[19] = 2'b10; drv_x[19] = 9158;
        run_batch("sigmoid sweep R5", 20);
    endtask

    task automatic t_saturation();
        int xt [6] = '{4579, 4580, -4579, -4580, 32767, -32768};
        int xg [6] = '{9158, 9159, -9158, -9159, 32767, -32768};
        for (int i = 0; i < 6; i++) begin
            drv_v[2*i] = 1;   drv_f[2*i] = 2'b01;   drv_x[2*i] = xt[i];
            drv_v[2*i+1] = 1; drv_f[2*i+1] = 2'b10; drv_x[2*i+1] = xg[i];
        end
        run_batch("saturation R6 R7", 12);
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 32; i++) begin
            drv_v[i] = 1;
            drv_f[i] = 2'(i % 4);
            drv_x[i] = ((i * 1373) % 12000) - 6000;
        end
        run_batch("mixed select R2 R8", 32);
    endtask

    task automatic t_bubbles();
        for (int i = 0; i < 18; i++) begin
            drv_v[i] = (i % 3 != 1);
            drv_f[i] = (i % 2 == 0) ? 2'b01 : 2'b00;
            drv_x[i] = i * 250 - 2000;
        end
        run_batch("bubbles R1", 18);
    endtask

    task automatic t_reset_flush();
        int seen = 0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_func = 2'b01; in_x = 16'(i * 100);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 out_valid during reset", int'(out_valid), 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check("R9 no stale result after reset", seen, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_relu();
        t_tanh_sweep();
        t_sig_sweep();
        t_saturation();
        t_mixed();
        t_bubbles();
        t_reset_flush();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule